// File: doc/BRIEF.md
# Event Status and Interrupt Vector Unit

This unit collects the one-cycle event strobes raised by the transfer engine of a serial-bus master controller and keeps each of them in a sticky status bit. Software clears these bits by writing ones. A separate enable register selects which events may raise the single level-sensitive interrupt line.

A compact vector register is kept for older software. Reading it returns a small code for the most urgent pending enabled event, and the read acknowledges that event by clearing its status bit. The status register also carries a live bus-busy indication, which comes straight from the bus monitor and is never stored.

All registers sit behind a simple word-wide read/write port. A read returns its data one cycle later, and a write takes effect at the next clock edge.

Top module: `evt_irq_unit`

## Requirements
- R1: After reset, the status register, the enable register, the read data and the interrupt output are all zero.
- R2: A one-cycle strobe on `evt_i` sets the matching sticky status bit, and the bit stays set after the strobe ends. The sticky positions are arbitration lost (0), no acknowledge (1), access ready (2), receive ready (3), transmit ready (4), general-call address (8), addressed as slave (9), transmit underflow (10), receive overrun (11), receive draining (13) and transmit draining (14). Strobes on any other position are ignored.
- R3: Writing the status register (address 1) clears every sticky bit whose written value is 1 and leaves unchanged every bit written as 0.
- R4: If an event strobe and a clear of the same status bit land in one cycle, the bit ends up set. The clear may come from a status write or from a vector read.
- R5: The enable register (address 0) stores only bits 0–4, 13 and 14. All other bits read back as 0.
- R6: `irq_o` is high exactly when some status bit and the same enable bit are both 1. It is a level and stays high until the cause is cleared or disabled.
- R7: Status bit 12 reads back the live value of `bus_busy_i`. It cannot be set by `evt_i[12]` and cannot be cleared by writes.
- R8: A read of the vector register (address 2) returns the code of the lowest-numbered pending enabled event among bits 0–4. The codes are 1 for arbitration lost, 2 for no acknowledge, 3 for access ready, 4 for receive ready and 5 for transmit ready. When none is pending and enabled, the code is 0. A pending but disabled event is skipped.
- R9: A vector read clears only the status bit of the event it reports.
- R10: `rdata_o` carries the value addressed by a read one cycle after `rd_en_i`, and holds that value while no read is issued. Address 3 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| evt_i | input | 16 | Single-cycle event strobes, one per status position |
| bus_busy_i | input | 1 | Live bus-busy level |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 2 | Register select: 0 enable, 1 status, 2 vector |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data, valid one cycle after the read |
| irq_o | output | 1 | Level interrupt request |

## Verification
The sticky logic is driven with an all-ones strobe, which separates the stored positions from the ignored ones. It is then hit with partial write-one masks and an all-zero write, which separates clearing from preserving. Strobes that coincide with a status-write clear or with a vector acknowledge show whether setting wins over clearing. The vector is read repeatedly after several events are raised together, so the reported order, the single-bit acknowledge and the skipping of disabled events each give distinct codes. Bus-busy is driven high while ones are written to bit 12, and low while bit 12 is strobed, which separates the live path from the stored bits.

// File: rtl/evt_irq_pkg.sv
package evt_irq_pkg;
  localparam int unsigned EVT_W = 16;

  localparam int unsigned B_ARB_LOST  = 0;
  localparam int unsigned B_NO_ACK    = 1;
  localparam int unsigned B_ACC_RDY   = 2;
  localparam int unsigned B_RX_RDY    = 3;
  localparam int unsigned B_TX_RDY    = 4;
  localparam int unsigned B_GEN_CALL  = 8;
  localparam int unsigned B_SLV_HIT   = 9;
  localparam int unsigned B_TX_UNDER  = 10;
  localparam int unsigned B_RX_OVER   = 11;
  localparam int unsigned B_BUS_BUSY  = 12;
  localparam int unsigned B_RX_DRAIN  = 13;
  localparam int unsigned B_TX_DRAIN  = 14;

  // vector sources occupy bits 0..VEC_N-1 in priority order
  localparam int unsigned VEC_N  = 5;
  localparam int unsigned VEC_CW = $clog2(VEC_N + 1);

  localparam logic [EVT_W-1:0] VEC_MASK = EVT_W'((1 << VEC_N) - 1);

  localparam logic [EVT_W-1:0] EN_MASK =
      VEC_MASK | (EVT_W'(1) << B_RX_DRAIN) | (EVT_W'(1) << B_TX_DRAIN);

  localparam logic [EVT_W-1:0] STICKY_MASK =
      EN_MASK | (EVT_W'(1) << B_GEN_CALL) | (EVT_W'(1) << B_SLV_HIT) |
      (EVT_W'(1) << B_TX_UNDER) | (EVT_W'(1) << B_RX_OVER);

  typedef enum logic [1:0] {
    RA_ENABLE = 2'd0,
    RA_STATUS = 2'd1,
    RA_VECTOR = 2'd2,
    RA_NONE   = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/evt_sticky_reg.sv
module evt_sticky_reg #(
  parameter int unsigned W = 16,
  parameter logic [W-1:0] MASK = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] q_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    if (MASK[i]) begin : g_flop
      logic b_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) b_q <= 1'b0;
        else if (set_i[i]) b_q <= 1'b1;   // set wins over clear
        else if (clr_i[i]) b_q <= 1'b0;
      end
      assign q_o[i] = b_q;
    end else begin : g_zero
      assign q_o[i] = 1'b0;
    end
  end
endmodule

// File: rtl/evt_vec_enc.sv
module evt_vec_enc #(
  parameter int unsigned N  = 5,
  parameter int unsigned CW = $clog2(N + 1)
) (
  input  logic [N-1:0]  pend_i,
  output logic [CW-1:0] code_o,
  output logic [N-1:0]  sel_o
);
  // scan high to low so the lowest pending index is left last
  always_comb begin
    code_o = '0;
    sel_o  = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (pend_i[i]) begin
        code_o = CW'(i + 1);
        sel_o  = N'(1) << i;
      end
    end
  end
endmodule

// File: rtl/evt_irq_unit.sv
module evt_irq_unit
  import evt_irq_pkg::*;
#(
  parameter int unsigned AW = 2,
  parameter int unsigned DW = EVT_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [DW-1:0] evt_i,
  input  logic          bus_busy_i,
  input  logic          wr_en_i,
  input  logic          rd_en_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic          irq_o
);
  localparam logic [DW-1:0] STK_M = DW'(STICKY_MASK);
  localparam logic [DW-1:0] ENA_M = DW'(EN_MASK);

  logic [DW-1:0]     status_q;
  logic [DW-1:0]     en_q;
  logic [DW-1:0]     status_view;
  logic [DW-1:0]     clr_mask;
  logic [DW-1:0]     rd_mux;
  logic [DW-1:0]     rdata_q;
  logic [VEC_N-1:0]  vec_pend;
  logic [VEC_N-1:0]  vec_sel;
  logic [VEC_CW-1:0] vec_code;
  logic              wr_stat, wr_en_reg, rd_vec;

  assign wr_stat   = wr_en_i && (addr_i == AW'(RA_STATUS));
  assign wr_en_reg = wr_en_i && (addr_i == AW'(RA_ENABLE));
  assign rd_vec    = rd_en_i && (addr_i == AW'(RA_VECTOR));

  assign vec_pend = status_q[VEC_N-1:0] & en_q[VEC_N-1:0];

  evt_vec_enc #(.N(VEC_N), .CW(VEC_CW)) u_enc (
    .pend_i (vec_pend),
    .code_o (vec_code),
    .sel_o  (vec_sel)
  );

  always_comb begin
    clr_mask = wr_stat ? wdata_i : '0;
    if (rd_vec) clr_mask = clr_mask | DW'(vec_sel);
  end

  evt_sticky_reg #(.W(DW), .MASK(STK_M)) u_stat (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (evt_i & STK_M),
    .clr_i  (clr_mask),
    .q_o    (status_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        en_q <= '0;
    else if (wr_en_reg) en_q <= wdata_i & ENA_M;
  end

  always_comb begin
    status_view             = status_q;
    status_view[B_BUS_BUSY] = bus_busy_i;
  end

  always_comb begin
    unique case (addr_i)
      AW'(RA_ENABLE): rd_mux = en_q;
      AW'(RA_STATUS): rd_mux = status_view;
      AW'(RA_VECTOR): rd_mux = DW'(vec_code);
      default:        rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rdata_q <= '0;
    else if (rd_en_i) rdata_q <= rd_mux;
  end

  assign rdata_o = rdata_q;
  assign irq_o   = |(status_q & en_q);
endmodule

// File: rtl/evt_irq_chk.sv
module evt_irq_chk
  import evt_irq_pkg::*;
#(
  parameter int unsigned AW = 2,
  parameter int unsigned DW = EVT_W
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [DW-1:0] evt_i,
  input logic          bus_busy_i,
  input logic          wr_en_i,
  input logic          rd_en_i,
  input logic [AW-1:0] addr_i,
  input logic [DW-1:0] wdata_i,
  input logic [DW-1:0] rdata_o,
  input logic          irq_o,
  input logic [DW-1:0] status_q,
  input logic [DW-1:0] en_q
);
  localparam logic [DW-1:0] STK_M = DW'(STICKY_MASK);
  localparam logic [DW-1:0] ENA_M = DW'(EN_MASK);

  p_set_wins_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(evt_i & STK_M)) |=> ((($past(evt_i) & STK_M) & ~status_q) == '0));

  p_clear_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == AW'(RA_STATUS) && evt_i == '0)
      |=> ((status_q & $past(wdata_i) & STK_M) == '0));

  p_en_store_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == AW'(RA_ENABLE)) |=> (en_q == ($past(wdata_i) & ENA_M)));

  p_irq_rise_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(evt_i & en_q) && !(wr_en_i && addr_i == AW'(RA_ENABLE))) |=> irq_o);

  p_busy_live_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && addr_i == AW'(RA_STATUS)) |=> (rdata_o[B_BUS_BUSY] == $past(bus_busy_i)));

  p_vec_range_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && addr_i == AW'(RA_VECTOR)) |=> (rdata_o <= DW'(VEC_N)));

  p_vec_ack_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && addr_i == AW'(RA_VECTOR) && !wr_en_i && evt_i == '0 && (|(status_q & en_q & DW'(VEC_MASK))))
      |=> ($countones($past(status_q)) == $countones(status_q) + 1));

  p_rdata_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> $stable(rdata_o));
endmodule

bind evt_irq_unit evt_irq_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .evt_i      (evt_i),
  .bus_busy_i (bus_busy_i),
  .wr_en_i    (wr_en_i),
  .rd_en_i    (rd_en_i),
  .addr_i     (addr_i),
  .wdata_i    (wdata_i),
  .rdata_o    (rdata_o),
  .irq_o      (irq_o),
  .status_q   (status_q),
  .en_q       (en_q)
);

// File: tb/sim_evt_irq_unit.sv
module sim_evt_irq_unit;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] evt = '0;
  logic        busy = 1'b0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [1:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        irq;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  evt_irq_unit u0 (
    .clk_i (clk), .rst_ni (rst_n), .evt_i (evt), .bus_busy_i (busy),
    .wr_en_i (wr_en), .rd_en_i (rd_en), .addr_i (addr), .wdata_i (wdata),
    .rdata_o (rdata), .irq_o (irq)
  );

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_reg(logic [1:0] a, logic [15:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; wdata = '0;
  endtask

  task automatic rd_reg(logic [1:0] a, output logic [15:0] v);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    v = rdata;
  endtask

  task automatic pulse(logic [15:0] e);
    evt = e;
    @(negedge clk);
    evt = '0;
  endtask

  task automatic t_reset();
    logic [15:0] v;
    check("R1 irq", {15'd0, irq}, 16'h0);
    check("R1 rdata", rdata, 16'h0);
    rd_reg(2'd0, v); check("R1 enable", v, 16'h0);
    rd_reg(2'd1, v); check("R1 status", v, 16'h0);
  endtask

  task automatic t_sticky();
    logic [15:0] v;
    pulse(16'hFFFF);
    repeat (2) @(negedge clk);
    rd_reg(2'd1, v); check("R2 sticky set", v, 16'h6F1F);
    check("R6 irq masked", {15'd0, irq}, 16'h0);
  endtask

  task automatic t_clear();
    logic [15:0] v;
    wr_reg(2'd1, 16'h0F03);
    rd_reg(2'd1, v); check("R3 partial clear", v, 16'h601C);
    wr_reg(2'd1, 16'h0000);
    rd_reg(2'd1, v); check("R3 zero write", v, 16'h601C);
    wr_reg(2'd1, 16'hFFFF);
    rd_reg(2'd1, v); check("R3 full clear", v, 16'h0000);
  endtask

  task automatic t_enable();
    logic [15:0] v;
    wr_reg(2'd0, 16'hFFFF);
    rd_reg(2'd0, v); check("R5 enable mask", v, 16'h601F);
  endtask

  task automatic t_irq();
    pulse(16'h2000);
    check("R6 irq on enabled", {15'd0, irq}, 16'h1);
    @(negedge clk);
    check("R6 irq level", {15'd0, irq}, 16'h1);
    wr_reg(2'd1, 16'h2000);
    check("R6 irq drop", {15'd0, irq}, 16'h0);
    pulse(16'h0100);
    check("R6 irq disabled src", {15'd0, irq}, 16'h0);
    wr_reg(2'd0, 16'h0000);
    pulse(16'h0010);
    check("R6 irq enable off", {15'd0, irq}, 16'h0);
    wr_reg(2'd0, 16'h0010);
    check("R6 irq late enable", {15'd0, irq}, 16'h1);
    wr_reg(2'd1, 16'hFFFF);
  endtask

  task automatic t_set_wins();
    logic [15:0] v;
    evt = 16'h0008; wr_en = 1'b1; addr = 2'd1; wdata = 16'h0008;
    @(negedge clk);
    evt = '0; wr_en = 1'b0; wdata = '0;
    rd_reg(2'd1, v); check("R4 set beats write clear", v, 16'h0008);
    wr_reg(2'd1, 16'hFFFF);
  endtask

  task automatic t_busy();
    logic [15:0] v;
    busy = 1'b1;
    wr_reg(2'd1, 16'h1000);
    rd_reg(2'd1, v); check("R7 busy live high", v, 16'h1000);
    busy = 1'b0;
    pulse(16'h1000);
    rd_reg(2'd1, v); check("R7 busy strobe ignored", v, 16'h0000);
  endtask

  task automatic t_vector();
    logic [15:0] v;
    wr_reg(2'd0, 16'h001F);
    pulse(16'h001A);
    rd_reg(2'd2, v); check("R8 vec first", v, 16'd2);
    rd_reg(2'd2, v); check("R8 vec second", v, 16'd4);
    rd_reg(2'd2, v); check("R8 vec third", v, 16'd5);
    rd_reg(2'd2, v); check("R8 vec none", v, 16'd0);
    rd_reg(2'd1, v); check("R9 all acked", v, 16'h0000);
    wr_reg(2'd0, 16'h0016);
    pulse(16'h0005);
    rd_reg(2'd2, v); check("R8 skip disabled", v, 16'd3);
    rd_reg(2'd1, v); check("R9 only reported bit cleared", v, 16'h0001);
    rd_reg(2'd2, v); check("R8 disabled not reported", v, 16'd0);
    pulse(16'h0004);
    evt = 16'h0004; rd_en = 1'b1; addr = 2'd2;
    @(negedge clk);
    evt = '0; rd_en = 1'b0;
    check("R8 vec with strobe", rdata, 16'd3);
    rd_reg(2'd1, v); check("R4 set beats vector ack", v, 16'h0005);
    wr_reg(2'd1, 16'hFFFF);
  endtask

  task automatic t_readport();
    logic [15:0] v;
    rd_reg(2'd0, v); check("R10 enable readback", v, 16'h0016);
    repeat (3) @(negedge clk);
    check("R10 rdata hold", rdata, 16'h0016);
    rd_reg(2'd3, v); check("R10 unused address", v, 16'h0000);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_sticky();
    t_clear();
    t_enable();
    t_irq();
    t_set_wins();
    t_busy();
    t_vector();
    t_readport();
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=%h expected=%h", 16'h1, 16'h0);
    finish_run();
  end
endmodule